// File: doc/BRIEF.md
# Dual-Mode 8-Bit PWM Timer

This block is an up-counting or up/down-counting timer that produces one pulse-width-modulated pin level from a compare value. A count-enable tick advances the counter, so the rate comes from a prescaler outside the block. A mode input selects between two waveforms:

- **Phase-correct:** the counter climbs from zero to its top value and falls back again.
- **Single-slope:** the counter climbs and wraps to zero.

Two sticky flags record turnaround/wrap events and compare matches. Each flag is cleared by a write-one strobe or by an interrupt acknowledge. Each flag raises its own interrupt request only when both its local enable and the global enable are set.

When the compare value sits at an end of its range, the pin is held at a fixed level instead of producing glitch pulses. In phase-correct mode this applies to both ends; in single-slope mode it applies only to the top value. All inputs are plain control and status pins, sampled on the rising clock edge. There is no streaming data path, so no valid/ready handshake and no back-pressure applies.

Top module: `pwm_timer8`

## Requirements
- R1: With `mode`=0 (phase-correct), each tick moves the counter up from 0 to 255, then down to 0, then up again. `ovf_flag` is set by the tick that moves the counter away from 0, and never by the tick at 255.
- R2: With `mode`=1 (single-slope), each tick increments the counter and wraps 255 to 0. `ovf_flag` is set by the wrapping tick.
- R3: `cmp_flag` is set by any tick taken while the counter equals `cmp_val`.
- R4: In phase-correct mode with `cmp_mode`=2'b10, a compare match while counting up drives `pwm_out` low and a match while counting down drives it high. With `cmp_mode`=2'b11 both levels are inverted.
- R5: In single-slope mode with `cmp_mode`=2'b10, the wrap drives `pwm_out` high and a compare match drives it low. With 2'b11 both levels are inverted.
- R6: In phase-correct mode with `cmp_mode[1]`=1 and `cmp_val` equal to 0 or 255, `pwm_out` is held at `(cmp_val==255) XOR cmp_mode[0]`.
- R7: In single-slope mode the held level of R6 applies only for `cmp_val`=255. With `cmp_val`=0 the pin follows R5.
- R8: With `cmp_mode[1]`=0, `pwm_out` is driven low.
- R9: `ovf_irq` = `ovf_flag` AND `ovf_ie` AND `gie`; `cmp_irq` = `cmp_flag` AND `cmp_ie` AND `gie`.
- R10: A flag is cleared by its write-one strobe (`ovf_w1c`/`cmp_w1c`) or its acknowledge (`ovf_ack`/`cmp_ack`). A set event in the same cycle wins, and the flag stays 1.
- R11: `rst` is synchronous and active-high. It zeroes the counter, sets the direction to up, and clears both flags and `pwm_out`.
- R12: With `tick`=0 the counter, the direction, the flags' set events and the pin level hold. The held level of R6 or R7 and the low level of R8 are the exception: they are applied on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable, one clock wide per step |
| mode | input | 1 | 0 = phase-correct up/down, 1 = single-slope wrap |
| cmp_val | input | 8 | Compare value |
| cmp_mode | input | 2 | Compare-output mode: [1] connects the pin, [0] inverts |
| ovf_ie | input | 1 | Turnaround/wrap interrupt enable |
| cmp_ie | input | 1 | Compare-match interrupt enable |
| gie | input | 1 | Global interrupt enable |
| ovf_w1c | input | 1 | Write-one clear of `ovf_flag` |
| cmp_w1c | input | 1 | Write-one clear of `cmp_flag` |
| ovf_ack | input | 1 | Interrupt acknowledge for `ovf_flag` |
| cmp_ack | input | 1 | Interrupt acknowledge for `cmp_flag` |
| pwm_out | output | 1 | PWM pin level (registered) |
| ovf_flag | output | 1 | Turnaround/wrap flag |
| cmp_flag | output | 1 | Compare-match flag |
| ovf_irq | output | 1 | Gated turnaround/wrap interrupt request |
| cmp_irq | output | 1 | Gated compare-match interrupt request |

## Verification
The embedded assertions watch every cycle for the following:
- the counter holding without a tick;
- the turnaround at zero and the wrap at the top;
- flag set and clear precedence;
- the pin being low whenever the output is disconnected.

The waveform-level behaviours can only be shown by the directed scenarios. These cover which edge each match produces in each direction, the held levels at the range ends and their mode-dependent exception, and the interrupt gating across all enable combinations. For these, the bench compares the pin, flags and requests cycle by cycle against its own model of the requirements.

// File: rtl/pwm_timer8_pkg.sv
package pwm_timer8_pkg;
  typedef enum logic {
    MODE_UPDOWN = 1'b0,
    MODE_WRAP   = 1'b1
  } pwm_mode_e;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } cnt_dir_e;

  // compare-output mode field layout
  localparam int CM_CONNECT = 1;
  localparam int CM_INVERT  = 0;

  // index of each flag in the flag bank
  localparam int FLG_OVF = 0;
  localparam int FLG_CMP = 1;
  localparam int NUM_FLG = 2;
endpackage

// File: rtl/pwm_cnt_core.sv
module pwm_cnt_core
  import pwm_timer8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  pwm_mode_e        mode,
  input  logic [WIDTH-1:0] cmp_val,
  output logic [WIDTH-1:0] cnt_o,
  output cnt_dir_e         dir_o,
  output logic             ovf_evt_o,
  output logic             match_evt_o
);
  localparam logic [WIDTH-1:0] TOP  = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] BOT  = '0;
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] cnt_q, cnt_d;
  cnt_dir_e         dir_q, dir_d;
  logic             at_top, at_bot;

  assign at_top = (cnt_q == TOP);
  assign at_bot = (cnt_q == BOT);

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    if (tick) begin
      if (mode == MODE_WRAP) begin
        cnt_d = cnt_q + ONE;
        dir_d = DIR_UP;
      end else if (dir_q == DIR_UP) begin
        if (at_top) begin
          cnt_d = TOP - ONE;
          dir_d = DIR_DOWN;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else begin
        if (at_bot) begin
          cnt_d = ONE;
          dir_d = DIR_UP;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  // phase-correct: event on leaving the bottom; single-slope: on wrapping
  always_comb begin
    if (mode == MODE_UPDOWN) ovf_evt_o = tick && at_bot;
    else                     ovf_evt_o = tick && at_top;
  end

  assign match_evt_o = tick && (cnt_q == cmp_val);
  assign cnt_o       = cnt_q;
  assign dir_o       = dir_q;

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q));
  // R2
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && mode == MODE_WRAP && at_top) |=> (cnt_q == BOT));
  // R1
  bottom_turn_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && mode == MODE_UPDOWN && at_bot) |=> (cnt_q == ONE && dir_q == DIR_UP));
  // R1
  top_turn_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && mode == MODE_UPDOWN && at_top && dir_q == DIR_UP) |=> (dir_q == DIR_DOWN));
endmodule

// File: rtl/pwm_wave_gen.sv
module pwm_wave_gen
  import pwm_timer8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  pwm_mode_e        mode,
  input  logic [WIDTH-1:0] cmp_val,
  input  logic [1:0]       cmp_mode,
  input  cnt_dir_e         dir,
  input  logic             ovf_evt,
  input  logic             match_evt,
  output logic             pwm_o
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] BOT = '0;

  logic connect, invert, cmp_top, cmp_bot, pin_fixed, fixed_lvl;
  logic out_q, out_d;

  assign connect = cmp_mode[CM_CONNECT];
  assign invert  = cmp_mode[CM_INVERT];
  assign cmp_top = (cmp_val == TOP);
  assign cmp_bot = (cmp_val == BOT);

  // range ends pin the level; single-slope honours only the top end
  assign pin_fixed = (mode == MODE_UPDOWN) ? (cmp_top || cmp_bot) : cmp_top;
  assign fixed_lvl = cmp_top ^ invert;

  always_comb begin
    out_d = out_q;
    if (!connect) begin
      out_d = 1'b0;
    end else if (pin_fixed) begin
      out_d = fixed_lvl;
    end else if (tick) begin
      if (mode == MODE_UPDOWN) begin
        if (match_evt) out_d = (dir == DIR_UP) ? invert : ~invert;
      end else begin
        if (match_evt)    out_d = invert;
        else if (ovf_evt) out_d = ~invert;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_q <= 1'b0;
    else     out_q <= out_d;
  end

  assign pwm_o = out_q;

  // R8
  disc_low_chk: assert property (@(posedge clk) disable iff (rst)
    !cmp_mode[CM_CONNECT] |=> !pwm_o);
  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && cmp_mode[CM_CONNECT] && !pin_fixed) |=> $stable(pwm_o));
endmodule

// File: rtl/pwm_flag_cell.sv
module pwm_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic ie_i,
  input  logic gie_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & ie_i & gie_i;

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);
  // R10
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_o);
  // R3
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    (!flag_o && !set_i) |=> !flag_o);
endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
  import pwm_timer8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             mode,
  input  logic [WIDTH-1:0] cmp_val,
  input  logic [1:0]       cmp_mode,
  input  logic             ovf_ie,
  input  logic             cmp_ie,
  input  logic             gie,
  input  logic             ovf_w1c,
  input  logic             cmp_w1c,
  input  logic             ovf_ack,
  input  logic             cmp_ack,
  output logic             pwm_out,
  output logic             ovf_flag,
  output logic             cmp_flag,
  output logic             ovf_irq,
  output logic             cmp_irq
);
  pwm_mode_e        mode_e;
  logic [WIDTH-1:0] cnt;
  cnt_dir_e         dir;
  logic             ovf_evt, match_evt;

  logic [NUM_FLG-1:0] f_set, f_clr, f_ie, f_val, f_irq;

  assign mode_e = pwm_mode_e'(mode);

  pwm_cnt_core #(.WIDTH(WIDTH)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode_e), .cmp_val(cmp_val),
    .cnt_o(cnt), .dir_o(dir), .ovf_evt_o(ovf_evt), .match_evt_o(match_evt)
  );

  pwm_wave_gen #(.WIDTH(WIDTH)) u_wave (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode_e), .cmp_val(cmp_val),
    .cmp_mode(cmp_mode), .dir(dir), .ovf_evt(ovf_evt), .match_evt(match_evt),
    .pwm_o(pwm_out)
  );

  assign f_set[FLG_OVF] = ovf_evt;
  assign f_set[FLG_CMP] = match_evt;
  assign f_clr[FLG_OVF] = ovf_w1c | ovf_ack;
  assign f_clr[FLG_CMP] = cmp_w1c | cmp_ack;
  assign f_ie[FLG_OVF]  = ovf_ie;
  assign f_ie[FLG_CMP]  = cmp_ie;

  for (genvar g = 0; g < NUM_FLG; g++) begin : g_flag
    pwm_flag_cell u_flag (
      .clk(clk), .rst(rst), .set_i(f_set[g]), .clr_i(f_clr[g]),
      .ie_i(f_ie[g]), .gie_i(gie), .flag_o(f_val[g]), .irq_o(f_irq[g])
    );
  end

  assign ovf_flag = f_val[FLG_OVF];
  assign cmp_flag = f_val[FLG_CMP];
  assign ovf_irq  = f_irq[FLG_OVF];
  assign cmp_irq  = f_irq[FLG_CMP];

  // R11
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!pwm_out && !ovf_flag && !cmp_flag && cnt == '0));
  // R1
  ud_no_top_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_e == MODE_UPDOWN && tick && cnt == {WIDTH{1'b1}}) |-> !ovf_evt);
endmodule

// File: tb/pwm_timer8_bench.sv
module pwm_timer8_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, mode = 1'b0;
  logic [7:0] cmp_val = 8'h00;
  logic [1:0] cmp_mode = 2'b00;
  logic ovf_ie = 1'b0, cmp_ie = 1'b0, gie = 1'b0;
  logic ovf_w1c = 1'b0, cmp_w1c = 1'b0, ovf_ack = 1'b0, cmp_ack = 1'b0;
  logic pwm_out, ovf_flag, cmp_flag, ovf_irq, cmp_irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // requirement model state
  logic [7:0] m_cnt = 8'h00;
  logic m_up = 1'b1, m_out = 1'b0, m_fo = 1'b0, m_fc = 1'b0;

  always #5 clk = ~clk;

  pwm_timer8 u_pwm_timer8 (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode), .cmp_val(cmp_val),
    .cmp_mode(cmp_mode), .ovf_ie(ovf_ie), .cmp_ie(cmp_ie), .gie(gie),
    .ovf_w1c(ovf_w1c), .cmp_w1c(cmp_w1c), .ovf_ack(ovf_ack), .cmp_ack(cmp_ack),
    .pwm_out(pwm_out), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag),
    .ovf_irq(ovf_irq), .cmp_irq(cmp_irq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // one clock: model next state from the requirements, then compare
  task automatic cyc(string req);
    logic [7:0] n_cnt;
    logic n_up, n_out, oe, ce, fixed;
    n_cnt = m_cnt; n_up = m_up; n_out = m_out;
    if (rst) begin
      n_cnt = 0; n_up = 1; n_out = 0; m_fo = 0; m_fc = 0;
    end else begin
      oe = tick && (mode ? (m_cnt == 8'hFF) : (m_cnt == 8'h00));
      ce = tick && (m_cnt == cmp_val);
      if (tick) begin
        if (mode) begin n_cnt = m_cnt + 1; n_up = 1; end
        else if (m_up) begin
          if (m_cnt == 8'hFF) begin n_cnt = 8'hFE; n_up = 0; end
          else n_cnt = m_cnt + 1;
        end else begin
          if (m_cnt == 8'h00) begin n_cnt = 1; n_up = 1; end
          else n_cnt = m_cnt - 1;
        end
      end
      fixed = mode ? (cmp_val == 8'hFF) : (cmp_val == 8'hFF || cmp_val == 8'h00);
      if (!cmp_mode[1]) n_out = 0;
      else if (fixed) n_out = (cmp_val == 8'hFF) ^ cmp_mode[0];
      else if (tick) begin
        if (!mode) begin
          if (ce) n_out = m_up ? cmp_mode[0] : ~cmp_mode[0];
        end else begin
          if (ce) n_out = cmp_mode[0];
          else if (oe) n_out = ~cmp_mode[0];
        end
      end
      m_fo = oe | (m_fo & ~(ovf_w1c | ovf_ack));
      m_fc = ce | (m_fc & ~(cmp_w1c | cmp_ack));
    end
    @(posedge clk);
    #1;
    m_cnt = n_cnt; m_up = n_up; m_out = n_out;
    check({req, " pwm"}, pwm_out, m_out);
    check({req, " ovf_flag"}, ovf_flag, m_fo);
    check({req, " cmp_flag"}, cmp_flag, m_fc);
    check({req, " ovf_irq"}, ovf_irq, m_fo & ovf_ie & gie);
    check({req, " cmp_irq"}, cmp_irq, m_fc & cmp_ie & gie);
  endtask

  task automatic run(string req, int n);
    for (int i = 0; i < n; i++) cyc(req);
  endtask

  task automatic do_reset();
    rst = 1; tick = 0;
    run("R11", 2);
    rst = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R11 reset pwm", pwm_out, 0);
    check("R11 reset ovf", ovf_flag, 0);
    check("R11 reset cmp", cmp_flag, 0);
  endtask

  task automatic t_updown();
    mode = 0; cmp_mode = 2'b10; cmp_val = 8'h40; tick = 1;
    cyc("R1");
    check("R1 flag leaving bottom", ovf_flag, 1);
    ovf_w1c = 1; cyc("R10"); ovf_w1c = 0;
    run("R1", 253);                       // counter now at 255
    check("R1 no flag at top", ovf_flag, 0);
    run("R4", 600);
    cmp_mode = 2'b11;
    run("R4 inverted", 600);
    for (int i = 0; i < 400; i++) begin   // sparse ticks
      tick = (i % 3) != 0;
      cyc("R12");
    end
    tick = 1;
  endtask

  task automatic t_wrap();
    do_reset();
    mode = 1; cmp_mode = 2'b10; cmp_val = 8'h80; tick = 1;
    run("R2", 255);                       // counter now at 255
    check("R2 no flag before wrap", ovf_flag, 0);
    cyc("R2");
    check("R2 flag at wrap", ovf_flag, 1);
    run("R5", 600);
    cmp_mode = 2'b11;
    run("R5 inverted", 600);
  endtask

  task automatic t_fixed();
    int hi;
    mode = 0; tick = 1;
    cmp_val = 8'h00; cmp_mode = 2'b10; run("R6", 520);
    check("R6 ud 00 ni", pwm_out, 0);
    cmp_mode = 2'b11; run("R6", 520);
    check("R6 ud 00 inv", pwm_out, 1);
    cmp_val = 8'hFF; cmp_mode = 2'b10; run("R6", 520);
    check("R6 ud FF ni", pwm_out, 1);
    cmp_mode = 2'b11; run("R6", 520);
    check("R6 ud FF inv", pwm_out, 0);
    mode = 1; cmp_mode = 2'b10; run("R7", 520);
    check("R7 wrap FF ni", pwm_out, 1);
    cmp_val = 8'h00; hi = 0;
    for (int i = 0; i < 600; i++) begin
      cyc("R7");
      if (pwm_out) hi++;
    end
    check("R7 wrap 00 toggles", (hi > 0 && hi < 600), 1);
  endtask

  task automatic t_disc();
    mode = 0; cmp_val = 8'h30; cmp_mode = 2'b00; tick = 1;
    run("R8", 300);
    check("R8 disconnected low", pwm_out, 0);
  endtask

  task automatic t_irq();
    mode = 1; cmp_val = 8'h10; cmp_mode = 2'b10; tick = 1;
    run("R9", 300);                       // both flags now set
    tick = 0;
    for (int k = 0; k < 8; k++) begin
      ovf_ie = k[0]; cmp_ie = k[1]; gie = k[2];
      cyc("R9");
      check("R9 ovf_irq gating", ovf_irq, k[0] & k[2]);
      check("R9 cmp_irq gating", cmp_irq, k[1] & k[2]);
    end
    ovf_ie = 1; cmp_ie = 1; gie = 1;
  endtask

  task automatic t_clear();
    tick = 0;
    ovf_ack = 1; cyc("R10"); ovf_ack = 0;
    check("R10 ack clears ovf", ovf_flag, 0);
    cmp_w1c = 1; cyc("R10"); cmp_w1c = 0;
    check("R10 w1c clears cmp", cmp_flag, 0);
    // same-cycle set and clear: wrap tick with clear asserted
    mode = 1; tick = 1;
    while (m_cnt != 8'hFF) cyc("R10");
    ovf_w1c = 1; ovf_ack = 1; cyc("R10"); ovf_w1c = 0; ovf_ack = 0;
    check("R10 set wins", ovf_flag, 1);
    run("R10", 300);
    rst = 1; cyc("R11"); rst = 0;
    check("R11 mid reset pwm", pwm_out, 0);
    check("R11 mid reset ovf", ovf_flag, 0);
  endtask

  initial begin
    t_reset();
    t_updown();
    t_wrap();
    t_fixed();
    t_disc();
    t_irq();
    t_clear();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule